// File: doc/BRIEF.md
# Banked memory address decoder

This block keeps four bank configuration words and uses them to map a physical address onto one of four memory banks. Each word holds a bank base address, a three-bit size code and a bank-enable bit. The decoder takes one address and returns, in the same cycle, whether some bank claims it, which bank it is, and how far into that bank the address lies. The memory datapath sits behind it and uses the bank index and offset to steer an access.

A configuration block drives the level of the controller's global enable and sends bank-word writes as an index with data. A bank takes part in decoding only while its own enable bit and the global enable are both set. When the global enable rises, all four words are loaded from build-time preset base and size parameters. This lets the memory come up already mapped without any software writes. A read port returns any bank word, so the stored contents can be observed.

Top module: `bank_addr_decoder`

## Requirements
- R1: After reset, every bank word reads 0 and no address produces a hit.
- R2: A write with `wr_en` high stores `wr_data & 32'hFFDEE001` into the word picked by `wr_idx` at the next rising clock edge. In a word, bits 31:23 are the base address, bits 19:17 are the size code and bit 0 is the bank enable.
- R3: A size code c from 0 to 6 gives a bank of (4 MiB << c) bytes, so sizes run from 4 MiB to 256 MiB.
- R4: A bank whose size code is 7 never produces a hit, even when it is enabled.
- R5: A bank can hit only while its bit 0 and the `glb_en` input are both 1. With `glb_en` low, `hit` is 0 for every address, and the bank words keep their values.
- R6: An address A hits bank k when base_k <= A < base_k + size_k. The sum is formed without wrapping, so a bank at the top of the address space covers up to 32'hFFFFFFFF. On a hit, `hit_bank` is k and `hit_offset` is A - base_k. With no hit, both are 0.
- R7: When several banks cover an address, the lowest-numbered one is reported.
- R8: At a clock edge where `glb_en` is 1 but was 0 at the previous edge (or at reset), each word is loaded from its preset. A preset with nonzero size gives the size code, the preset base ANDed with 32'hFF800000, and bit 0 set. A preset with zero size gives 0.
- R9: A nonzero preset size other than 4, 8, 16, 32, 64, 128 or 256 MiB loads the word with 0.
- R10: At a preset-load edge, the preset value wins over a bank write in the same cycle. While `glb_en` stays high, no reload takes place and writes take effect as normal.
- R11: Decode is combinational: `hit`, `hit_bank` and `hit_offset` follow `lookup_addr` and the present bank words in the same cycle, and `rd_data` shows the word picked by `rd_idx` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global controller enable level; its rise loads the presets |
| wr_en | input | 1 | Bank word write strobe |
| wr_idx | input | 2 | Index of the bank word written |
| wr_data | input | 32 | Write data, masked before it is stored |
| rd_idx | input | 2 | Index of the bank word read back |
| rd_data | output | 32 | Bank word picked by rd_idx |
| lookup_addr | input | 32 | Physical address to decode |
| hit | output | 1 | Some enabled bank covers lookup_addr |
| hit_bank | output | 2 | Index of the claiming bank, lowest wins |
| hit_offset | output | 32 | lookup_addr minus the claiming bank's base |

## Verification
The properties assume that `glb_en`, `wr_en`, `wr_idx` and `wr_data` change only between clock edges and settle before the next rising edge. They also assume that `wr_idx` always names one of the four banks. The assertions take a hit as valid only when the reported bank's stored word is enabled and has a legal size code. The bench drives all inputs just after a rising edge, using only in-range indices, and it raises and lowers `glb_en` as whole-cycle levels. Each edge therefore sees one clear rising or steady enable and, at most, one write.

// File: rtl/bdec_pkg.sv
package bdec_pkg;

  localparam int WORD_W = 32;
  localparam int CODE_W = 3;
  localparam int CODE_LSB = 17;
  localparam int NUM_CODES = 7;

  localparam logic [WORD_W-1:0] STORE_MASK = 32'hFFDEE001;
  localparam logic [WORD_W-1:0] BASE_MASK = 32'hFF800000;
  localparam logic [WORD_W-1:0] UNIT_BYTES = 32'h0040_0000;
  localparam logic [CODE_W-1:0] CODE_BAD = 3'd7;

  // Bank byte count for a size code; the invalid code yields zero.
  function automatic logic [WORD_W:0] code_bytes(input logic [CODE_W-1:0] code);
    if (code == CODE_BAD) return '0;
    return {1'b0, UNIT_BYTES} << code;
  endfunction

  // Extract fields of a stored bank word.
  function automatic logic [WORD_W-1:0] word_base(input logic [WORD_W-1:0] w);
    return w & BASE_MASK;
  endfunction

  function automatic logic [CODE_W-1:0] word_code(input logic [WORD_W-1:0] w);
    return w[CODE_LSB +: CODE_W];
  endfunction

  // Build the word loaded from a preset base and byte size.
  function automatic logic [WORD_W-1:0] preset_word(input logic [WORD_W-1:0] base,
                                                    input logic [WORD_W-1:0] bytes);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int c = 0; c < NUM_CODES; c++) begin
      if (bytes == (UNIT_BYTES << c)) begin
        w = (base & BASE_MASK) | (WORD_W'(c) << CODE_LSB) | 32'h1;
      end
    end
    return w;
  endfunction

endpackage

// File: rtl/bdec_bank_reg.sv
module bdec_bank_reg #(
  parameter logic [31:0] PRE_BASE = 32'h0,
  parameter logic [31:0] PRE_BYTES = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        preset_load,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] word_q
);
  import bdec_pkg::*;

  localparam logic [WORD_W-1:0] PRE_WORD = preset_word(PRE_BASE, PRE_BYTES);

  // Preset load outranks a same-cycle write.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (preset_load) begin
      word_q <= PRE_WORD;
    end else if (wr_sel) begin
      word_q <= wr_data & STORE_MASK;
    end
  end

endmodule

// File: rtl/bdec_bank_match.sv
module bdec_bank_match (
  input  logic        glb_en,
  input  logic [31:0] word,
  input  logic [31:0] addr,
  output logic        match,
  output logic [31:0] offset
);
  import bdec_pkg::*;

  logic [WORD_W-1:0] base;
  logic [CODE_W-1:0] code;
  logic [WORD_W:0]   span;
  logic              unused_bits;

  assign base = word_base(word);
  assign code = word_code(word);
  assign span = code_bytes(code);
  assign unused_bits = ^{word[22:20], word[16:1]};

  // Offset formed in full width; the compare against the span cannot wrap.
  assign offset = addr - base;

  always_comb begin
    match = glb_en && word[0] && (code != CODE_BAD) &&
            (addr >= base) && ({1'b0, offset} < span);
  end

endmodule

// File: rtl/bdec_prio_sel.sv
module bdec_prio_sel #(
  parameter int NUM_BANKS = 4,
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [NUM_BANKS-1:0]       match,
  input  logic [NUM_BANKS-1:0][31:0] offsets,
  output logic                       hit,
  output logic [IDX_W-1:0]           idx,
  output logic [31:0]                offset
);

  // Scan from the top so the lowest matching index is the last assignment.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    offset = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
        offset = offsets[i];
      end
    end
  end

endmodule

// File: rtl/bank_addr_decoder.sv
module bank_addr_decoder #(
  parameter int NUM_BANKS = 4,
  parameter logic [NUM_BANKS-1:0][31:0] PRE_BASES = {32'h0C000000, 32'h08000000,
                                                    32'h04000000, 32'h00000000},
  parameter logic [NUM_BANKS-1:0][31:0] PRE_SIZES = {32'h04000000, 32'h04000000,
                                                    32'h04000000, 32'h04000000},
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_data,
  input  logic [31:0]      lookup_addr,
  output logic             hit,
  output logic [IDX_W-1:0] hit_bank,
  output logic [31:0]      hit_offset
);

  logic                       glb_en_q;
  logic                       preset_load;
  logic [NUM_BANKS-1:0][31:0] bank_flat;
  logic [NUM_BANKS-1:0][31:0] bank_off;
  logic [NUM_BANKS-1:0]       bank_match;

  always_ff @(posedge clk) begin
    if (!rst_n) glb_en_q <= 1'b0;
    else        glb_en_q <= glb_en;
  end

  // Rising global enable: reload every bank from its preset.
  assign preset_load = glb_en & ~glb_en_q;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    bdec_bank_reg #(
      .PRE_BASE (PRE_BASES[g]),
      .PRE_BYTES(PRE_SIZES[g])
    ) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .preset_load(preset_load),
      .wr_sel     (wr_en && (wr_idx == IDX_W'(g))),
      .wr_data    (wr_data),
      .word_q     (bank_flat[g])
    );

    bdec_bank_match u_match (
      .glb_en(glb_en),
      .word  (bank_flat[g]),
      .addr  (lookup_addr),
      .match (bank_match[g]),
      .offset(bank_off[g])
    );
  end

  bdec_prio_sel #(.NUM_BANKS(NUM_BANKS)) u_sel (
    .match  (bank_match),
    .offsets(bank_off),
    .hit    (hit),
    .idx    (hit_bank),
    .offset (hit_offset)
  );

  assign rd_data = bank_flat[rd_idx];

endmodule

// File: rtl/bdec_checker.sv
module bdec_checker #(
  parameter int NUM_BANKS = 4,
  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       glb_en,
  input logic                       wr_en,
  input logic [IDX_W-1:0]           wr_idx,
  input logic [31:0]                wr_data,
  input logic [31:0]                lookup_addr,
  input logic                       hit,
  input logic [IDX_W-1:0]           hit_bank,
  input logic [31:0]                hit_offset,
  input logic                       preset_load,
  input logic [NUM_BANKS-1:0][31:0] bank_flat
);

  assert_off_no_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !hit);

  assert_hit_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> bank_flat[hit_bank][0]);

  assert_hit_code_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (bank_flat[hit_bank][19:17] != 3'd7));

  assert_offset_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((hit_offset + (bank_flat[hit_bank] & 32'hFF800000)) == lookup_addr));

  assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_bank == '0 && hit_offset == '0));

  assert_preset_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    preset_load |-> glb_en);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
    assert_write_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(g) && !preset_load) |=>
        (bank_flat[g] == ($past(wr_data) & 32'hFFDEE001)));

    assert_preset_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
      preset_load |=> (bank_flat[g] == 32'h0) ||
        (bank_flat[g][0] && bank_flat[g][19:17] != 3'd7 &&
         (bank_flat[g] & 32'h007FFFFE & ~32'h000E0000) == 32'h0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && wr_idx == IDX_W'(g)) && !preset_load) |=> $stable(bank_flat[g]));
  end

endmodule

bind bank_addr_decoder bdec_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .glb_en     (glb_en),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .lookup_addr(lookup_addr),
  .hit        (hit),
  .hit_bank   (hit_bank),
  .hit_offset (hit_offset),
  .preset_load(preset_load),
  .bank_flat  (bank_flat)
);

// File: tb/bank_addr_decoder_tb.sv
module bank_addr_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MIB = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        glb_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic [31:0] lookup_addr = '0;
  logic        hit;
  logic [1:0]  hit_bank;
  logic [31:0] hit_offset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bank_addr_decoder #(
    .NUM_BANKS(4),
    .PRE_BASES({32'h10000000, 32'h30000000, 32'h04123456, 32'h00000000}),
    .PRE_SIZES({12 * MIB, 32'h0, 32 * MIB, 64 * MIB})
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .lookup_addr(lookup_addr), .hit(hit), .hit_bank(hit_bank), .hit_offset(hit_offset)
  );

  typedef struct {
    bit          is_rd;
    logic        e_hit;
    logic [1:0]  e_bank;
    logic [31:0] e_val;
    string       req;
  } item_t;

  item_t sb[$];

  // Bank word built by hand from base, size code and enable.
  function automatic logic [31:0] mk(input logic [31:0] base, input int code, input bit en);
    return (base & 32'hFF800000) | (32'(code) << 17) | 32'(en);
  endfunction

  // Monitor: compare outputs at the falling edge against queued items.
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (it.is_rd) begin
          if (rd_data !== it.e_val) begin
            errors++;
            $display("FAIL %s rd_data actual %h expected %h", it.req, rd_data, it.e_val);
          end
        end else if (hit !== it.e_hit || hit_bank !== it.e_bank || hit_offset !== it.e_val) begin
          errors++;
          $display("FAIL %s lookup %h actual hit=%b bank=%0d off=%h expected hit=%b bank=%0d off=%h",
                   it.req, lookup_addr, hit, hit_bank, hit_offset, it.e_hit, it.e_bank, it.e_val);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input logic eh, input logic [1:0] eb,
                      input logic [31:0] eo, input string req);
    item_t it;
    step();
    lookup_addr = a;
    it = '{is_rd: 1'b0, e_hit: eh, e_bank: eb, e_val: eo, req: req};
    sb.push_back(it);
  endtask

  task automatic rd(input logic [1:0] i, input logic [31:0] ev, input string req);
    item_t it;
    step();
    rd_idx = i;
    it = '{is_rd: 1'b1, e_hit: 1'b0, e_bank: 2'd0, e_val: ev, req: req};
    sb.push_back(it);
  endtask

  task automatic wr(input logic [1:0] i, input logic [31:0] d);
    step();
    wr_en = 1'b1;
    wr_idx = i;
    wr_data = d;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 4; i++) rd(2'(i), 32'h0, "R1");
    look(32'h0, 1'b0, 2'd0, 32'h0, "R1");

    // R8 R9 preset load on rising enable
    step(); glb_en = 1'b1;
    rd(2'd0, 32'h00080001, "R8");
    rd(2'd1, 32'h04060001, "R8");
    rd(2'd2, 32'h0, "R8");
    rd(2'd3, 32'h0, "R9");

    // R6 R3 R11 range decode
    look(32'h00000000, 1'b1, 2'd0, 32'h0, "R6");
    look(32'h03FFFFFC, 1'b1, 2'd0, 32'h03FFFFFC, "R3");
    look(32'h04000000, 1'b1, 2'd1, 32'h0, "R6");
    look(32'h05FFFFFF, 1'b1, 2'd1, 32'h01FFFFFF, "R3");
    look(32'h06000000, 1'b0, 2'd0, 32'h0, "R6");

    // R2 masking; R4 code 7 never hits
    wr(2'd2, 32'hFFFFFFFF);
    rd(2'd2, 32'hFFDEE001, "R2");
    look(32'hFF800000, 1'b0, 2'd0, 32'h0, "R4");
    look(32'hFFFFFFF0, 1'b0, 2'd0, 32'h0, "R4");

    // R3 16 MiB bank
    wr(2'd2, mk(32'h08000000, 2, 1'b1));
    look(32'h08ABCDEF, 1'b1, 2'd2, 32'h00ABCDEF, "R3");
    look(32'h09000000, 1'b0, 2'd0, 32'h0, "R3");

    // R7 overlap, lowest wins; R3 256 MiB
    wr(2'd3, mk(32'h08000000, 6, 1'b1));
    look(32'h08000010, 1'b1, 2'd2, 32'h10, "R7");
    look(32'h0A000000, 1'b1, 2'd3, 32'h02000000, "R3");
    look(32'h17FFFFFF, 1'b1, 2'd3, 32'h0FFFFFFF, "R3");
    look(32'h18000000, 1'b0, 2'd0, 32'h0, "R3");

    // R5 bank enable bit clear lets bank 3 take over
    wr(2'd2, mk(32'h08000000, 2, 1'b0));
    look(32'h08000010, 1'b1, 2'd3, 32'h10, "R5");

    // R5 global enable low: no hit, words retained
    step(); glb_en = 1'b0;
    look(32'h00000100, 1'b0, 2'd0, 32'h0, "R5");
    look(32'h0A000000, 1'b0, 2'd0, 32'h0, "R5");
    rd(2'd3, 32'h080C0001, "R5");

    // R10 preset beats simultaneous write at rising edge; R8 reload
    step(); glb_en = 1'b1; wr_en = 1'b1; wr_idx = 2'd0; wr_data = 32'hFFFFFFFF;
    rd(2'd0, 32'h00080001, "R10");
    rd(2'd3, 32'h0, "R8");
    rd(2'd2, 32'h0, "R8");

    // R10 steady enable: writes apply, no reload; R3 code 0
    wr(2'd0, mk(32'h20000000, 0, 1'b1));
    step();
    rd(2'd0, 32'h20000001, "R10");
    look(32'h203FFFFF, 1'b1, 2'd0, 32'h003FFFFF, "R3");
    look(32'h20400000, 1'b0, 2'd0, 32'h0, "R3");

    // R6 top of address space
    wr(2'd1, mk(32'hFF800000, 1, 1'b1));
    look(32'hFFFFFFFF, 1'b1, 2'd1, 32'h007FFFFF, "R6");
    look(32'hFF7FFFFF, 1'b0, 2'd0, 32'h0, "R6");

    step(); step();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule